// File: doc/BRIEF.md
# Signed Binary to Residue Encoder

This block maps a two's-complement binary word onto its residue with respect to a small fixed modulus, and can multiply by a fixed constant during the same mapping. It is the entry point of a residue-arithmetic datapath: binary samples arrive here, and each leaves as one small ring element that the later modular stages use.

The datapath is a chain of identical add-or-pass cells, one for each input bit, with the least significant bit handled first. Each cell holds a fixed modular increment, which is the bit's binary weight multiplied by the scale constant and reduced by the modulus. When the cell's bit is set, it adds that increment to the running residue. When the bit is clear, it passes the running residue through unchanged. The cell for the sign bit holds the negated increment instead, so negative words need no separate step. The increment can be applied through a small computed lookup table or through an adder with a conditional subtract. A parameter selects which one.

A word presented with `in_valid` enters the chain and moves one cell per clock. A new word may be accepted on every clock.

Top module: `sres_encoder`

## Requirements
- R1: When `out_valid` is high, `out_residue` equals (SCALE·X) mod MODULUS, reduced into the range [0, MODULUS). X is `in_word` read as a two's-complement integer.
- R2: A word sampled with `in_valid` high at rising edge k appears with `out_valid` high after rising edge k+WIDTH_IN−1, so it passes WIDTH_IN register stages. `out_valid` is never high unless a word is in flight.
- R3: Valid words on consecutive clocks each give their own result, one per clock, in arrival order.
- R4: In a cycle with `in_valid` low, `in_word` has no effect, and the matching output slot has `out_valid` low.
- R5: A high `rst` at a rising edge discards every word in flight. `out_valid` then stays low until a word sampled after reset reaches the end of the chain.
- R6: Bit WIDTH_IN−1 of `in_word` carries weight −2^(WIDTH_IN−1). A word with only that bit set gives (−2^(WIDTH_IN−1)·SCALE) mod MODULUS, which is 2 with the default parameters.
- R7: With WIDTH_IN=16, MODULUS=11 and SCALE=13, the input −29 (16'hFFE3) gives 8.
- R8: The all-zero word gives 0. The all-ones word (−1) gives (−SCALE) mod MODULUS, which is 9 with the default parameters.
- R9: Every valid output residue, and every partial residue held inside the chain, is less than MODULUS.
- R10: The lookup-table variant (TABLE_MODE=1) and the adder variant (TABLE_MODE=0) give identical results with identical timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | WIDTH_IN | Two's-complement binary word |
| out_valid | output | 1 | Qualifies `out_residue` |
| out_residue | output | clog2(MODULUS) | Scaled residue of the word |

## Verification
A word sampled at rising edge k is due at the output after edge k+WIDTH_IN−1. With the default width of 16, that is fifteen edges later. The bench records every sampled word, with its arithmetically computed residue, in a ring buffer indexed by the edge count. At each falling edge it compares the outputs with the entry written WIDTH_IN−1 edges earlier. A reset edge wipes the ring, so every slot in flight must come out invalid. Idle slots are expected invalid whatever data was on the input. A second instance built with the other increment variant is held to the same expected stream.

// File: rtl/sres_pkg.sv
package sres_pkg;

   // Width of one residue of modulus m.
   function automatic int res_width(input int m);
      return (m <= 2) ? 1 : $clog2(m);
   endfunction

   // Modular increment of cell j in an l-cell chain:
   // (2^j * a) mod m, negated for the sign cell j = l-1.
   function automatic longint stage_weight(input int j, input int l,
                                           input int m, input int a);
      longint w;
      longint mm;
      mm = longint'(m);
      w  = 1 % mm;
      for (int k = 0; k < j; k++) begin
         w = (w * 2) % mm;
      end
      w = (w * (longint'(a) % mm)) % mm;
      if (j == l - 1) begin
         w = (mm - w) % mm;
      end
      return w;
   endfunction

endpackage

// File: rtl/sres_modadd.sv
module sres_modadd #(
   parameter int MODULUS    = 11,
   parameter int ADDEND     = 0,
   parameter int TABLE_MODE = 1,
   localparam int RW        = sres_pkg::res_width(MODULUS)
) (
   input  logic [RW-1:0] a_i,
   output logic [RW-1:0] s_o
);

   if (TABLE_MODE == 1) begin : g_tbl
      // Entry k holds (k + ADDEND) mod MODULUS; the entries step by one
      // around the ring, starting from the cell's increment.
      logic [RW-1:0] tbl [MODULUS];
      for (genvar k = 0; k < MODULUS; k++) begin : g_ent
         assign tbl[k] = RW'((k + ADDEND) % MODULUS);
      end
      assign s_o = tbl[a_i];
   end else begin : g_arith
      localparam logic [RW:0] ADD_W = (RW+1)'(ADDEND);
      localparam logic [RW:0] MOD_W = (RW+1)'(MODULUS);
      logic [RW:0] raw;
      assign raw = {1'b0, a_i} + ADD_W;
      assign s_o = RW'((raw >= MOD_W) ? (raw - MOD_W) : raw);
   end

   // R1: the sum of an in-range operand matches the ring addition
   always_comb begin
      if (!$isunknown(a_i) && (int'(a_i) < MODULUS)) begin
         a_r1_sum_mod: assert (int'(s_o) == (int'(a_i) + ADDEND) % MODULUS);
      end
   end

endmodule

// File: rtl/sres_cell.sv
module sres_cell #(
   parameter int MODULUS    = 11,
   parameter int ADDEND     = 0,
   parameter int TABLE_MODE = 1,
   localparam int RW        = sres_pkg::res_width(MODULUS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          vld_i,
   input  logic          bit_i,
   input  logic [RW-1:0] res_i,
   output logic          vld_o,
   output logic [RW-1:0] res_o
);

   logic [RW-1:0] sum;
   logic [RW-1:0] res_d;

   sres_modadd #(
      .MODULUS   (MODULUS),
      .ADDEND    (ADDEND),
      .TABLE_MODE(TABLE_MODE)
   ) u_add (
      .a_i(res_i),
      .s_o(sum)
   );

   // add the increment when the bit is set, otherwise steer through
   always_comb res_d = bit_i ? sum : res_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
         res_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            res_o <= res_d;
         end
      end
   end

   // R9: a partial residue held in the chain stays inside the ring
   a_r9_cell_range: assert property (@(posedge clk) disable iff (rst)
      vld_o |-> (int'(res_o) < MODULUS));

endmodule

// File: rtl/sres_encoder.sv
module sres_encoder #(
   parameter int WIDTH_IN   = 16,
   parameter int MODULUS    = 11,
   parameter int SCALE      = 13,
   parameter int TABLE_MODE = 1,
   localparam int RW        = sres_pkg::res_width(MODULUS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [WIDTH_IN-1:0] in_word,
   output logic                out_valid,
   output logic [RW-1:0]       out_residue
);

   // elaboration-time parameter checks
   if (WIDTH_IN < 2 || WIDTH_IN > 62) begin : g_bad_width
      $error("sres_encoder: WIDTH_IN must lie in 2..62");
   end
   if (MODULUS < 2 || MODULUS > 65536) begin : g_bad_mod
      $error("sres_encoder: MODULUS must lie in 2..65536");
   end
   if (SCALE < 0) begin : g_bad_scale
      $error("sres_encoder: SCALE must not be negative");
   end
   if (TABLE_MODE != 0 && TABLE_MODE != 1) begin : g_bad_mode
      $error("sres_encoder: TABLE_MODE must be 0 or 1");
   end
   if (TABLE_MODE == 1 && MODULUS > 1024) begin : g_bad_tbl
      $error("sres_encoder: table variant limited to MODULUS <= 1024");
   end

   logic [WIDTH_IN:0] vld_p;
   logic [RW-1:0]     res_p [WIDTH_IN+1];

   assign vld_p[0] = in_valid;
   assign res_p[0] = '0;

   for (genvar j = 0; j < WIDTH_IN; j++) begin : g_st
      localparam int REM_W  = WIDTH_IN - j;
      localparam int ADDEND = int'(sres_pkg::stage_weight(j, WIDTH_IN, MODULUS, SCALE));

      // bits still to be consumed; bit 0 belongs to this cell
      logic [REM_W-1:0] rem_in;

      if (j == 0) begin : g_src
         assign rem_in = in_word;
      end else begin : g_src
         assign rem_in = g_st[j-1].g_fwd.rem_q;
      end

      if (j < WIDTH_IN - 1) begin : g_fwd
         logic [REM_W-2:0] rem_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               rem_q <= '0;
            end else if (vld_p[j]) begin
               rem_q <= rem_in[REM_W-1:1];
            end
         end
      end

      sres_cell #(
         .MODULUS   (MODULUS),
         .ADDEND    (ADDEND),
         .TABLE_MODE(TABLE_MODE)
      ) u_cell (
         .clk  (clk),
         .rst  (rst),
         .vld_i(vld_p[j]),
         .bit_i(rem_in[0]),
         .res_i(res_p[j]),
         .vld_o(vld_p[j+1]),
         .res_o(res_p[j+1])
      );
   end

   assign out_valid   = vld_p[WIDTH_IN];
   assign out_residue = res_p[WIDTH_IN];

   // occupancy counter kept only for the checks below
   localparam int CW = $clog2(WIDTH_IN + 2) + 1;
   logic [CW-1:0] inflight;

   always_ff @(posedge clk) begin
      if (rst) begin
         inflight <= '0;
      end else begin
         inflight <= inflight + CW'(in_valid) - CW'(out_valid);
      end
   end

   // R2: no result without a word that entered earlier
   a_r2_no_orphan: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (inflight != '0));

   // R2: the chain never holds more words than it has cells
   a_r2_inflight_bound: assert property (@(posedge clk) disable iff (rst)
      inflight <= CW'(WIDTH_IN));

   // R5: a reset edge leaves no valid result behind it
   a_r5_reset_clear: assert property (@(posedge clk)
      rst |=> !out_valid);

   // R9: every valid result lies in [0, MODULUS)
   a_r9_out_range: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_residue) < MODULUS));

endmodule

// File: tb/sres_encoder_test.sv
`timescale 1ns/1ps
module sres_encoder_test;

   localparam int L  = 16;
   localparam int M  = 11;
   localparam int A  = 13;
   localparam int RW = 4;
   localparam int HB = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [L-1:0]  in_word = '0;
   logic          out_valid, out_valid_alt;
   logic [RW-1:0] out_residue, out_residue_alt;

   always #10 clk = ~clk;

   sres_encoder #(.WIDTH_IN(L), .MODULUS(M), .SCALE(A), .TABLE_MODE(1)) uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid), .out_residue(out_residue));

   sres_encoder #(.WIDTH_IN(L), .MODULUS(M), .SCALE(A), .TABLE_MODE(0)) uut_alt (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid_alt), .out_residue(out_residue_alt));

   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   bit    done   = 1'b0;
   string cur_rtag = "R1";
   string cur_vtag = "R3";

   bit    h_vld  [HB];
   int    h_exp  [HB];
   string h_rtag [HB];
   string h_vtag [HB];

   function automatic int model(input logic [L-1:0] w);
      longint x;
      longint r;
      x = longint'($signed(w));
      r = (x * A) % M;
      if (r < 0) r += M;
      return int'(r);
   endfunction

   task automatic check_int(input string tag, input string what,
                            input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // record what the DUT sampled at each rising edge
   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < HB; i++) begin
            h_vld[i]  = 1'b0;
            h_vtag[i] = "R5";
         end
      end else begin
         h_vld[cyc % HB]  = in_valid;
         h_exp[cyc % HB]  = model(in_word);
         h_rtag[cyc % HB] = cur_rtag;
         h_vtag[cyc % HB] = in_valid ? cur_vtag : "R4";
      end
      cyc++;
   end

   // compare at the falling edge with the word sampled L-1 edges earlier (R2)
   always @(negedge clk) begin
      int    src;
      bit    ev;
      string vt;
      if (cyc > 0 && !done) begin
         src = cyc - L;
         ev  = (src >= 0) ? h_vld[src % HB] : 1'b0;
         vt  = (src >= 0) ? h_vtag[src % HB] : "R5";
         check_int(vt, "out_valid", int'(out_valid), int'(ev));
         check_int("R10", "alt out_valid", int'(out_valid_alt), int'(ev));
         if (ev) begin
            check_int(h_rtag[src % HB], "out_residue", int'(out_residue), h_exp[src % HB]);
            check_int("R10", "alt out_residue", int'(out_residue_alt), h_exp[src % HB]);
            check_int("R9", "residue below modulus", int'(out_residue < RW'(M)), 1);
         end
      end
   end

   task automatic drive(input bit v, input logic [L-1:0] w,
                        input string rt, input string vt);
      @(negedge clk);
      in_valid = v;
      in_word  = w;
      cur_rtag = rt;
      cur_vtag = vt;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // reset state, observed by the checker during the reset cycles (R5)
      // named corner words
      drive(1'b1, 16'hFFE3, "R7", "R2");   // -29 -> 8
      drive(1'b1, 16'h8000, "R6", "R2");   // sign bit only -> 2
      drive(1'b1, 16'h0000, "R8", "R2");   // zero -> 0
      drive(1'b1, 16'hFFFF, "R8", "R2");   // -1 -> 9
      drive(1'b0, 16'h5A5A, "R4", "R4");
      // bubbles with changing data on idle cycles (R4)
      for (int i = 0; i < 60; i++) begin
         drive((i % 3) == 0, 16'(i * 2731 + 7), "R4", "R4");
      end
      // exhaustive back-to-back sweep (R1, R3)
      for (int v = 0; v < 65536; v++) begin
         drive(1'b1, 16'(v), "R1", "R3");
      end
      for (int i = 0; i < L + 2; i++) drive(1'b0, 16'hFFFF, "R4", "R4");
      // reset in the middle of a stream (R5)
      for (int i = 0; i < 10; i++) drive(1'b1, 16'(i * 977 + 3), "R1", "R3");
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b1;
      in_word = 16'h1111;
      @(negedge clk);
      rst = 1'b0;
      in_valid = 1'b0;
      for (int i = 0; i < L + 2; i++) drive(1'b0, 16'h2222, "R5", "R5");
      drive(1'b1, 16'hFFE3, "R5", "R5");
      for (int i = 0; i < L + 2; i++) drive(1'b0, 16'h3333, "R4", "R4");
      @(negedge clk);
      done = 1'b1;
      finish_run();
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R3 watchdog: actual unfinished expected finished");
         finish_run();
      end
   end

endmodule